// File: doc/BRIEF.md
# Serial Flash Configuration Register Unit

This unit is the part of a serial NOR flash slave that owns the three configuration registers: a 16-bit non-volatile word, an 8-bit volatile byte and an 8-bit enhanced volatile byte. A SPI front end has already turned the serial line into whole bytes. It hands each incoming byte over a valid/ready stream. The unit returns readback bytes on a second valid/ready stream. A plain select input marks the chip-select window. Each window carries one command: an opcode byte, then either data bytes to collect or bytes to return.

The unit also holds the write-enable latch, the 4-byte addressing flag and the extended address byte. A two-step software reset rebuilds the volatile state from fields of the non-volatile word. That word keeps its value through the reset. Neighbouring logic reads the resulting register values from plain output pins. For example, it takes the dummy-cycle count from the upper nibble of the volatile byte.

Stream rules:
- Input: `rx_ready` equals `sel`, so the unit never stalls an incoming byte inside a window. A byte moves when `rx_valid && rx_ready`.
- Output: `tx_valid` is high only while a read command is active. While `tx_valid && !tx_ready`, `tx_data` holds its value. Each accepted byte moves on to the next register byte.

Top module: `cfgreg_unit`

## Requirements
- R1: After hardware reset, the non-volatile word equals parameter `NV_RESET` (default 0x8FFF). The volatile and enhanced bytes are derived from it as in R9 and R10, which gives 0x83 and 0xDF. The write-enable latch is 0. The 4-byte flag is 0 when bit 0 of `NV_RESET` is 1. The extended address is 0x00 when bit 1 of `NV_RESET` is 1.
- R2: Opcode 0x06 sets the write-enable latch. Completing any register write clears the latch.
- R3: Opcodes 0xB1, 0x81 and 0x61 are ignored when the write-enable latch is 0. No data bytes are taken, and the registers and the latch are unchanged.
- R4: Opcode 0xB1 writes the non-volatile word from two bytes, low byte first. Opcode 0xB5 returns the word as two bytes, low byte first.
- R5: Opcodes 0x81 and 0x85 write and read the volatile byte. Opcodes 0x61 and 0x65 write and read the enhanced volatile byte. Each transfer is one byte.
- R6: Within one read window, every byte requested after the register's defined bytes is 0xFF.
- R7: Deasserting `sel` before a write has all its bytes leaves the target register unchanged and the latch still set. The next window starts again from a fresh opcode.
- R8: A software reset happens only when opcode 0x99 arrives and the previous opcode was 0x66. The two opcodes come in separate windows. Opcode 0x99 on its own does nothing. The reset clears the write-enable latch.
- R9: On software reset, the volatile byte gets bits [1:0] = 2'b11 and bit 2 = 0. Bit 3 is 1 unless non-volatile bits [11:9] equal 3'b111. Bits [7:4] come from non-volatile bits [15:12].
- R10: On software reset, the enhanced byte gets bits [4:0] = 5'b11111 and bit 5 = 0. Bit 6 is non-volatile bit 1, and bit 7 is non-volatile bit 3.
- R11: On software reset, the non-volatile word is kept. The 4-byte flag is set if non-volatile bit 0 is 0, and is otherwise left as it was. The extended address is loaded with `EXT_ON_RESET` (default 0x03) if non-volatile bit 1 is 0, and is otherwise left as it was. The 4-byte flag is never cleared.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_data` stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset (power-up) |
| sel | input | 1 | Chip-select window, active high |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Incoming byte accepted (equals `sel`) |
| rx_data | input | 8 | Incoming opcode or data byte |
| tx_valid | output | 1 | Readback byte valid |
| tx_ready | input | 1 | Readback byte taken |
| tx_data | output | 8 | Readback byte |
| wel_o | output | 1 | Write-enable latch |
| addr4_o | output | 1 | 4-byte address mode flag |
| ext_addr_o | output | 8 | Extended address byte |
| nv_cfg_o | output | 16 | Non-volatile configuration word |
| vol_cfg_o | output | 8 | Volatile configuration byte |
| evol_cfg_o | output | 8 | Enhanced volatile configuration byte |

## Verification
Four behaviours are checked on every cycle:
- readback bytes hold still under back-pressure;
- the non-volatile word cannot change while the write-enable latch is clear;
- any change to that word clears the latch;
- the 4-byte flag never drops.

The bench scenarios cover the rest:
- byte ordering and the 0xFF fill past the defined bytes;
- the aborted write;
- the need for 0x66 before 0x99;
- the exact bit fields rebuilt by a software reset for two different non-volatile values.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int BYTE_W = 8;
  localparam int NV_W   = 2 * BYTE_W;
  localparam int IDX_W  = 2;
  localparam logic [IDX_W-1:0] IDX_MAX = 2'd2;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_RST_EN  = 8'h66;
  localparam logic [7:0] OP_RST_MEM = 8'h99;
  localparam logic [7:0] OP_RD_NV   = 8'hB5;
  localparam logic [7:0] OP_WR_NV   = 8'hB1;
  localparam logic [7:0] OP_RD_V    = 8'h85;
  localparam logic [7:0] OP_WR_V    = 8'h81;
  localparam logic [7:0] OP_RD_EV   = 8'h65;
  localparam logic [7:0] OP_WR_EV   = 8'h61;

  typedef enum logic [1:0] {PH_IDLE, PH_COLLECT, PH_READ, PH_DONE} phase_t;
  typedef enum logic [1:0] {TG_NV, TG_V, TG_EV} tgt_t;

  // Volatile byte rebuilt from the non-volatile word
  function automatic logic [BYTE_W-1:0] vol_from_nv(input logic [NV_W-1:0] nv);
    logic [BYTE_W-1:0] v;
    v      = 8'h03;
    v[3]   = (nv[11:9] != 3'b111);
    v[7:4] = nv[15:12];
    return v;
  endfunction

  // Enhanced volatile byte rebuilt from the non-volatile word
  function automatic logic [BYTE_W-1:0] evol_from_nv(input logic [NV_W-1:0] nv);
    logic [BYTE_W-1:0] e;
    e    = 8'h1F;
    e[6] = nv[1];
    e[7] = nv[3];
    return e;
  endfunction
endpackage

// File: rtl/cfgreg_decode.sv
module cfgreg_decode
  import cfgreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rx_fire,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              tx_fire,
  input  logic              wel,
  output logic              rd_active,
  output tgt_t              rd_tgt,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              wr_nv,
  output logic              wr_v,
  output logic              wr_ev,
  output logic [NV_W-1:0]   wr_data,
  output logic              set_wel,
  output logic              soft_rst
);
  phase_t            phase;
  tgt_t              tgt;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] lo_byte;
  logic              rst_arm;
  logic              op_fire;
  logic              last_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      tgt     <= TG_NV;
      idx     <= '0;
      lo_byte <= '0;
      rst_arm <= 1'b0;
    end else if (!sel) begin
      phase <= PH_IDLE;
      idx   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (rx_fire) begin
          idx     <= '0;
          rst_arm <= (rx_data == OP_RST_EN);
          phase   <= PH_DONE;
          case (rx_data)
            OP_RD_NV: begin phase <= PH_READ; tgt <= TG_NV; end
            OP_RD_V:  begin phase <= PH_READ; tgt <= TG_V;  end
            OP_RD_EV: begin phase <= PH_READ; tgt <= TG_EV; end
            OP_WR_NV: if (wel) begin phase <= PH_COLLECT; tgt <= TG_NV; end
            OP_WR_V:  if (wel) begin phase <= PH_COLLECT; tgt <= TG_V;  end
            OP_WR_EV: if (wel) begin phase <= PH_COLLECT; tgt <= TG_EV; end
            default: ;
          endcase
        end
        PH_COLLECT: if (rx_fire) begin
          if (tgt == TG_NV && idx == '0) begin
            lo_byte <= rx_data;
            idx     <= 2'd1;
          end else begin
            phase <= PH_DONE;
          end
        end
        PH_READ: if (tx_fire && idx != IDX_MAX) idx <= idx + 2'd1;
        default: ;
      endcase
    end
  end

  always_comb begin
    op_fire   = sel && phase == PH_IDLE && rx_fire;
    last_byte = sel && phase == PH_COLLECT && rx_fire && (tgt != TG_NV || idx == 2'd1);
    wr_nv     = last_byte && tgt == TG_NV;
    wr_v      = last_byte && tgt == TG_V;
    wr_ev     = last_byte && tgt == TG_EV;
    wr_data   = (tgt == TG_NV) ? {rx_data, lo_byte} : {{BYTE_W{1'b0}}, rx_data};
    set_wel   = op_fire && rx_data == OP_WREN;
    soft_rst  = op_fire && rx_data == OP_RST_MEM && rst_arm;
    rd_active = sel && phase == PH_READ;
    rd_tgt    = tgt;
    rd_idx    = idx;
  end
endmodule

// File: rtl/cfgreg_store.sv
module cfgreg_store
  import cfgreg_pkg::*;
#(
  parameter logic [15:0] NV_RESET     = 16'h8FFF,
  parameter logic [7:0]  EXT_ON_RESET = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_nv,
  input  logic              wr_v,
  input  logic              wr_ev,
  input  logic [NV_W-1:0]   wr_data,
  input  logic              set_wel,
  input  logic              soft_rst,
  output logic [NV_W-1:0]   nv_cfg,
  output logic [BYTE_W-1:0] vol_cfg,
  output logic [BYTE_W-1:0] evol_cfg,
  output logic              wel,
  output logic              addr4,
  output logic [BYTE_W-1:0] ext_addr
);
  localparam logic [BYTE_W-1:0] VOL_PWR  = vol_from_nv(NV_RESET);
  localparam logic [BYTE_W-1:0] EVOL_PWR = evol_from_nv(NV_RESET);
  localparam logic [BYTE_W-1:0] EXT_PWR  = NV_RESET[1] ? '0 : EXT_ON_RESET;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_cfg   <= NV_RESET;
      vol_cfg  <= VOL_PWR;
      evol_cfg <= EVOL_PWR;
      wel      <= 1'b0;
      addr4    <= ~NV_RESET[0];
      ext_addr <= EXT_PWR;
    end else if (soft_rst) begin
      vol_cfg  <= vol_from_nv(nv_cfg);
      evol_cfg <= evol_from_nv(nv_cfg);
      wel      <= 1'b0;
      if (!nv_cfg[0]) addr4    <= 1'b1;
      if (!nv_cfg[1]) ext_addr <= EXT_ON_RESET;
    end else begin
      if (wr_nv) nv_cfg   <= wr_data;
      if (wr_v)  vol_cfg  <= wr_data[BYTE_W-1:0];
      if (wr_ev) evol_cfg <= wr_data[BYTE_W-1:0];
      if (wr_nv || wr_v || wr_ev) wel <= 1'b0;
      else if (set_wel)           wel <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgreg_unit.sv
module cfgreg_unit
  import cfgreg_pkg::*;
#(
  parameter logic [15:0] NV_RESET     = 16'h8FFF,
  parameter logic [7:0]  EXT_ON_RESET = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        wel_o,
  output logic        addr4_o,
  output logic [7:0]  ext_addr_o,
  output logic [15:0] nv_cfg_o,
  output logic [7:0]  vol_cfg_o,
  output logic [7:0]  evol_cfg_o
);
  logic             rd_active;
  tgt_t             rd_tgt;
  logic [IDX_W-1:0] rd_idx;
  logic             wr_nv, wr_v, wr_ev, set_wel, soft_rst;
  logic [NV_W-1:0]  wr_data;
  logic             rx_fire, tx_fire;

  assign rx_ready = sel;
  assign rx_fire  = rx_valid && sel;
  assign tx_valid = rd_active;
  assign tx_fire  = rd_active && tx_ready;

  cfgreg_decode u_dec (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rx_fire(rx_fire), .rx_data(rx_data),
    .tx_fire(tx_fire), .wel(wel_o), .rd_active(rd_active), .rd_tgt(rd_tgt),
    .rd_idx(rd_idx), .wr_nv(wr_nv), .wr_v(wr_v), .wr_ev(wr_ev), .wr_data(wr_data),
    .set_wel(set_wel), .soft_rst(soft_rst)
  );

  cfgreg_store #(.NV_RESET(NV_RESET), .EXT_ON_RESET(EXT_ON_RESET)) u_st (
    .clk(clk), .rst_n(rst_n), .wr_nv(wr_nv), .wr_v(wr_v), .wr_ev(wr_ev),
    .wr_data(wr_data), .set_wel(set_wel), .soft_rst(soft_rst),
    .nv_cfg(nv_cfg_o), .vol_cfg(vol_cfg_o), .evol_cfg(evol_cfg_o),
    .wel(wel_o), .addr4(addr4_o), .ext_addr(ext_addr_o)
  );

  // Readback byte select; anything past the defined bytes is all ones
  always_comb begin
    tx_data = 8'hFF;
    case (rd_tgt)
      TG_NV: begin
        if (rd_idx == 2'd0)      tx_data = nv_cfg_o[7:0];
        else if (rd_idx == 2'd1) tx_data = nv_cfg_o[15:8];
      end
      TG_V:  if (rd_idx == 2'd0) tx_data = vol_cfg_o;
      TG_EV: if (rd_idx == 2'd0) tx_data = evol_cfg_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/cfgreg_unit_chk.sv
module cfgreg_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        wel_o,
  input logic        addr4_o,
  input logic [15:0] nv_cfg_o
);
  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!tx_valid || $stable(tx_data)));

  // R3
  nv_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel_o |=> $stable(nv_cfg_o));

  // R2
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nv_cfg_o) |-> !wel_o);

  // R11
  addr4_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(addr4_o));
endmodule

bind cfgreg_unit cfgreg_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .wel_o(wel_o), .addr4_o(addr4_o), .nv_cfg_o(nv_cfg_o)
);

// File: tb/sim_cfgreg_unit.sv
`timescale 1ns/1ps
module sim_cfgreg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = 8'h00;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        wel_o, addr4_o;
  logic [7:0]  ext_addr_o, vol_cfg_o, evol_cfg_o;
  logic [15:0] nv_cfg_o;

  int nchk = 0;
  int nfail = 0;
  int popped = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  cfgreg_unit u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .wel_o(wel_o), .addr4_o(addr4_o), .ext_addr_o(ext_addr_o), .nv_cfg_o(nv_cfg_o),
    .vol_cfg_o(vol_cfg_o), .evol_cfg_o(evol_cfg_o)
  );

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // Monitor: sample mid-cycle, a transfer completes at the next rising edge
  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL unexpected readback actual=%h expected=none", tx_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (tx_data !== e) begin
          nfail++;
          $display("FAIL %s readback actual=%h expected=%h", t, tx_data, e);
        end
      end
      popped++;
    end
  end

  task automatic tick; @(posedge clk); #1; endtask
  task automatic cs_on; sel = 1'b1; tick; endtask
  task automatic cs_off; sel = 1'b0; tick; tick; endtask
  task automatic put_byte(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b; tick; rx_valid = 1'b0;
  endtask
  task automatic cmd1(input logic [7:0] op);
    cs_on; put_byte(op); cs_off;
  endtask
  task automatic cmd2(input logic [7:0] op, input logic [7:0] b0);
    cs_on; put_byte(op); put_byte(b0); cs_off;
  endtask
  task automatic cmd3(input logic [7:0] op, input logic [7:0] b0, input logic [7:0] b1);
    cs_on; put_byte(op); put_byte(b0); put_byte(b1); cs_off;
  endtask
  // Driver: push expected bytes (byte 0 in e[7:0]) and pull n bytes
  task automatic rd(input logic [7:0] op, input int n, input logic [23:0] e, input string r);
    int target;
    cs_on; put_byte(op);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(e[8*i +: 8]);
      tag_q.push_back(r);
    end
    target = popped + n;
    tx_ready = 1'b1;
    while (popped < target) tick;
    tx_ready = 1'b0;
    cs_off;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired, run hung");
      summary;
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // R1 power-up state
    chk("R1 nv", nv_cfg_o, 16'h8FFF);
    chk("R1 vol", {8'h0, vol_cfg_o}, 16'h0083);
    chk("R1 evol", {8'h0, evol_cfg_o}, 16'h00DF);
    chk("R1 wel", {15'h0, wel_o}, 16'h0);
    chk("R1 addr4", {15'h0, addr4_o}, 16'h0);
    chk("R1 ext", {8'h0, ext_addr_o}, 16'h0);
    chk("R1 rx_ready idle", {15'h0, rx_ready}, 16'h0);
    // R4 R6: low byte, high byte, then fill
    rd(8'hB5, 3, 24'hFF_8F_FF, "R4 R6 nv read");
    // R3 write without latch is ignored
    cmd2(8'h81, 8'h55);
    chk("R3 vol unchanged", {8'h0, vol_cfg_o}, 16'h0083);
    cmd3(8'hB1, 8'h11, 8'h22);
    chk("R3 nv unchanged", nv_cfg_o, 16'h8FFF);
    rd(8'h85, 2, 24'h00_FF_83, "R5 R6 vol read");
    // R2 R5 volatile write
    cmd1(8'h06);
    chk("R2 wel set", {15'h0, wel_o}, 16'h1);
    cmd2(8'h81, 8'h5A);
    chk("R5 vol written", {8'h0, vol_cfg_o}, 16'h005A);
    chk("R2 wel cleared", {15'h0, wel_o}, 16'h0);
    rd(8'h85, 1, 24'h00_00_5A, "R5 vol read");
    cmd1(8'h06);
    cmd2(8'h61, 8'h12);
    chk("R5 evol written", {8'h0, evol_cfg_o}, 16'h0012);
    rd(8'h65, 2, 24'h00_FF_12, "R5 R6 evol read");
    // R7 aborted non-volatile write
    cmd1(8'h06);
    cmd2(8'hB1, 8'h34);
    chk("R7 nv unchanged", nv_cfg_o, 16'h8FFF);
    chk("R7 wel kept", {15'h0, wel_o}, 16'h1);
    cmd3(8'hB1, 8'h04, 8'h3A);
    chk("R4 nv written", nv_cfg_o, 16'h3A04);
    chk("R2 wel cleared nv", {15'h0, wel_o}, 16'h0);
    rd(8'hB5, 2, 24'h00_3A_04, "R4 nv read");
    // R8 lone reset-memory opcode does nothing
    cmd1(8'h99);
    chk("R8 lone 99", {8'h0, vol_cfg_o}, 16'h005A);
    cmd1(8'h06);
    cmd1(8'h66);
    cmd1(8'h99);
    chk("R8 wel cleared", {15'h0, wel_o}, 16'h0);
    chk("R9 vol derived", {8'h0, vol_cfg_o}, 16'h003B);
    chk("R10 evol derived", {8'h0, evol_cfg_o}, 16'h001F);
    chk("R11 addr4 set", {15'h0, addr4_o}, 16'h1);
    chk("R11 ext loaded", {8'h0, ext_addr_o}, 16'h0003);
    chk("R11 nv kept", nv_cfg_o, 16'h3A04);
    // second derivation: nv 0x0E0A
    cmd1(8'h06);
    cmd3(8'hB1, 8'h0A, 8'h0E);
    cmd1(8'h66);
    cmd1(8'h99);
    chk("R9 vol derived 2", {8'h0, vol_cfg_o}, 16'h0003);
    chk("R10 evol derived 2", {8'h0, evol_cfg_o}, 16'h00DF);
    chk("R11 addr4 kept", {15'h0, addr4_o}, 16'h1);
    chk("R11 ext kept", {8'h0, ext_addr_o}, 16'h0003);
    // R12 back-pressure on readback
    cs_on; put_byte(8'h85);
    tx_ready = 1'b0;
    tick;
    chk("R12 valid", {15'h0, tx_valid}, 16'h1);
    held = tx_data;
    tick; tick;
    chk("R12 held", {8'h0, tx_data}, {8'h0, held});
    chk("R12 value", {8'h0, tx_data}, 16'h0003);
    exp_q.push_back(8'h03); tag_q.push_back("R12 after stall");
    begin
      int target;
      target = popped + 1;
      tx_ready = 1'b1;
      while (popped < target) tick;
      tx_ready = 1'b0;
    end
    cs_off;
    chk("R6 queue drained", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    summary;
    $finish;
  end
endmodule